// File: doc/BRIEF.md
# Plesiochronous Elastic Buffer with Idle Slip

This block carries 10-bit line characters from the clock recovered out of the incoming serial stream into the receiver's local clock. The two clocks are nominally equal but run from different oscillators. A dual-clock storage ring sits between them. Each side keeps a binary pointer and publishes it to the other side as a Gray code through a two-flop synchronizer. The two clocks may therefore be fully unrelated in phase.

The frequency difference is absorbed only in the slack between packets. A packet is a run of consecutive non-idle characters, and the gaps between packets hold idle characters. When the writer sees the buffer filling past a high mark, it discards incoming idles. When the reader sees the buffer draining below a low mark, and the character it last delivered was an idle, it sends out an extra idle and leaves its pointer where it is. Because of these two rules, packet contents are never stretched or shortened.

If the offset or the packet length exceeds what the depth can cover, the result is a true overflow or a true underflow. Each raises a sticky flag on the local-clock side. The depth has to be chosen from the worst-case frequency offset multiplied by the longest packet, plus the synchronizer lag on each side.

Top module: `efb_elastic`

## Requirements
- R1: With no overflow, every non-idle character accepted at the write port appears at the read port exactly once and in write order.
- R2: Each pointer crosses to the other clock as a Gray code through two flops, and a published pointer code changes by at most one bit per clock.
- R3: An idle character (code IDLE_CHAR, default 10'h17C) that arrives while write-side occupancy is above HI_MARK (default 12) is discarded. Such a character leaves the write pointer unchanged.
- R4: No idle is inserted between two characters of one packet. At the read port, once the first character of a packet has been delivered, every further valid character up to the end of that packet is the packet's next character.
- R5: A character that arrives while write-side occupancy equals the depth (default 16) is discarded. It sets the overflow output, which passes through two read-clock flops and stays high until reset.
- R6: When read-side occupancy is below LO_MARK (default 4) and the last delivered character was an idle, the reader outputs IDLE_CHAR with rd_valid high and does not advance. With a steady input stream, rd_valid therefore stays high.
- R7: When the buffer is empty and the last delivered character was not an idle, rd_valid is low for that cycle. The underflow output goes high and stays high until reset.
- R8: While in reset, rd_valid, overflow and underflow are all low, and the reader treats its last delivered character as an idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered clock (write side) |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write side |
| wr_valid | input | 1 | A character is present on wr_data this cycle |
| wr_data | input | 10 | Coded character from the deserializer |
| rd_clk | input | 1 | Local receive clock (read side) |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read side |
| rd_valid | output | 1 | rd_data holds a character this cycle |
| rd_data | output | 10 | Character delivered in the local clock domain |
| overflow | output | 1 | Sticky: a character was lost because the buffer was full |
| underflow | output | 1 | Sticky: the reader ran dry inside a packet |

## Verification
The read outputs are registered, so a read-side decision shows up one rd_clk edge after the occupancy it was based on. A written character reaches that decision only after its write edge and two rd_clk synchronizer flops. Because of this variable lag, the bench does not predict exact cycles for the data. It compares the delivered non-idle stream in order against a queue filled at the write port, and it samples every output on the falling edge of rd_clk. The sticky flags are checked only after a settling window of several read clocks, which covers the two-flop overflow crossing.

// File: rtl/efb_pkg.sv
package efb_pkg;
  typedef enum logic [1:0] {
    ACT_POP    = 2'd0,
    ACT_FILL   = 2'd1,
    ACT_STARVE = 2'd2
  } rd_act_e;
endpackage

// File: rtl/efb_sync.sv
module efb_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/efb_wr_ctrl.sv
module efb_wr_ctrl #(
  parameter int          AW        = 4,
  parameter int          W         = 10,
  parameter int          HI_MARK   = 12,
  parameter logic [W-1:0] IDLE_CHAR = 10'h17C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [W-1:0]  wr_data,
  input  logic [AW:0]   rgray_s,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] waddr,
  output logic          wen,
  output logic          ovf_sticky
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wbin, rbin_s, occ;
  logic          drop_idle, ovf_evt;

  assign rbin_s    = g2b(rgray_s);
  assign occ       = wbin - rbin_s;
  assign drop_idle = wr_valid && (wr_data == IDLE_CHAR) && (occ > PW'(HI_MARK));
  assign ovf_evt   = wr_valid && !drop_idle && (occ == PW'(DEPTH));
  assign wen       = wr_valid && !drop_idle && !ovf_evt;
  assign waddr     = wbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin       <= '0;
      wgray      <= '0;
      ovf_sticky <= 1'b0;
    end else begin
      if (wen) begin
        wbin  <= wbin + 1'b1;
        wgray <= b2g(wbin + 1'b1);
      end
      if (ovf_evt) ovf_sticky <= 1'b1;
    end
  end

  a_r2_wgray_step: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wgray ^ $past(wgray)));
  a_r3_idle_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_data == IDLE_CHAR && occ > PW'(HI_MARK)) |=> (wbin == $past(wbin)));
  a_r5_full_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_data != IDLE_CHAR && occ == PW'(DEPTH)) |=> ovf_sticky);
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_sticky |=> ovf_sticky);
endmodule

// File: rtl/efb_rd_ctrl.sv
module efb_rd_ctrl
  import efb_pkg::*;
#(
  parameter int           AW        = 4,
  parameter int           W         = 10,
  parameter int           LO_MARK   = 4,
  parameter logic [W-1:0] IDLE_CHAR = 10'h17C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW:0]   wgray_s,
  input  logic [W-1:0]  mem_q,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid,
  output logic          udf_sticky
);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] rbin, wbin_s, occ;
  logic          last_idle;
  rd_act_e       act;

  assign wbin_s = g2b(wgray_s);
  assign occ    = wbin_s - rbin;
  assign raddr  = rbin[AW-1:0];

  always_comb begin
    if (occ == '0)                              act = last_idle ? ACT_FILL : ACT_STARVE;
    else if (occ < PW'(LO_MARK) && last_idle)   act = ACT_FILL;
    else                                        act = ACT_POP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin       <= '0;
      rgray      <= '0;
      rd_data    <= IDLE_CHAR;
      rd_valid   <= 1'b0;
      last_idle  <= 1'b1;
      udf_sticky <= 1'b0;
    end else begin
      unique case (act)
        ACT_POP: begin
          rd_data   <= mem_q;
          rd_valid  <= 1'b1;
          last_idle <= (mem_q == IDLE_CHAR);
          rbin      <= rbin + 1'b1;
          rgray     <= b2g(rbin + 1'b1);
        end
        ACT_FILL: begin
          rd_data  <= IDLE_CHAR;
          rd_valid <= 1'b1;
        end
        default: begin
          rd_valid   <= 1'b0;
          udf_sticky <= 1'b1;
        end
      endcase
    end
  end

  a_r2_rgray_step: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rgray ^ $past(rgray)));
  a_r4_pop_in_packet: assert property (@(posedge clk) disable iff (!rst_n)
    (!last_idle && occ != '0) |=> (rd_valid && rd_data == $past(mem_q)));
  a_r7_starve: assert property (@(posedge clk) disable iff (!rst_n)
    (!last_idle && occ == '0) |=> (!rd_valid && udf_sticky));
  a_r7_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    udf_sticky |=> udf_sticky);
endmodule

// File: rtl/efb_elastic.sv
module efb_elastic #(
  parameter int           AW        = 4,
  parameter int           W         = 10,
  parameter int           HI_MARK   = 12,
  parameter int           LO_MARK   = 4,
  parameter logic [W-1:0] IDLE_CHAR = 10'h17C
) (
  input  logic         wr_clk,
  input  logic         wr_rst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         rd_clk,
  input  logic         rd_rst_n,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         overflow,
  output logic         underflow
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic          wen, ovf_w;
  logic [0:0]    ovf_s;

  efb_wr_ctrl #(.AW(AW), .W(W), .HI_MARK(HI_MARK), .IDLE_CHAR(IDLE_CHAR)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr), .wen(wen), .ovf_sticky(ovf_w));

  efb_rd_ctrl #(.AW(AW), .W(W), .LO_MARK(LO_MARK), .IDLE_CHAR(IDLE_CHAR)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .wgray_s(wgray_s), .mem_q(mem[raddr]),
    .raddr(raddr), .rgray(rgray), .rd_data(rd_data), .rd_valid(rd_valid),
    .udf_sticky(underflow));

  efb_sync #(.W(AW + 1)) u_w2r (.clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_s));
  efb_sync #(.W(AW + 1)) u_r2w (.clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_s));
  efb_sync #(.W(1))      u_ovf (.clk(rd_clk), .rst_n(rd_rst_n), .d(ovf_w), .q(ovf_s));

  assign overflow = ovf_s[0];

  always_ff @(posedge wr_clk) begin
    if (wen) mem[waddr] <= wr_data;
  end

  a_r8_reset_quiet: assert property (@(posedge rd_clk)
    !rd_rst_n |-> (!rd_valid && !underflow && !overflow));
endmodule

// File: tb/sim_efb_elastic.sv
`timescale 1ps/1ps
module sim_efb_elastic;
  localparam logic [9:0] IDLE = 10'h17C;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [9:0] wr_data = IDLE;
  logic rd_valid, overflow, underflow;
  logic [9:0] rd_data;

  int unsigned wr_half = 10000;
  int nvec = 0, nbad = 0;
  bit sb_on = 1'b0, chk_valid = 1'b0, in_pkt = 1'b0, done = 1'b0;
  logic [10:0] expq[$];

  always #(wr_half) wr_clk = ~wr_clk;
  always #10000 rd_clk = ~rd_clk;

  efb_elastic u0 (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_valid(rd_valid), .rd_data(rd_data),
    .overflow(overflow), .underflow(underflow));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] rand_char();
    logic [9:0] d;
    do d = 10'($urandom % 1024); while (d == IDLE);
    return d;
  endfunction

  task automatic put(input logic [9:0] c, input bit last);
    @(negedge wr_clk);
    wr_valid = 1'b1;
    wr_data  = c;
    if (sb_on && c != IDLE) expq.push_back({last, c});
  endtask

  task automatic idles(input int n);
    for (int i = 0; i < n; i++) put(IDLE, 1'b0);
  endtask

  task automatic packet(input int len);
    for (int i = 0; i < len; i++) put(rand_char(), i == len - 1);
  endtask

  task automatic do_reset();
    sb_on = 1'b0; chk_valid = 1'b0; in_pkt = 1'b0;
    wr_valid = 1'b0;
    wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    expq.delete();
    repeat (4) @(negedge rd_clk);
    // R8: quiet outputs while held in reset
    chk(!rd_valid && !overflow && !underflow, "R8 reset state",
        {rd_valid, overflow, underflow}, 0);
    wr_rst_n = 1'b1; rd_rst_n = 1'b1;
  endtask

  // read-side scoreboard, sampled away from the rd_clk rising edge
  always @(negedge rd_clk) begin
    if (sb_on && rd_rst_n) begin
      if (chk_valid) chk(rd_valid, "R6 valid held by idle fill", rd_valid, 1);
      if (rd_valid) begin
        if (rd_data != IDLE) begin
          if (expq.size() == 0) chk(1'b0, "R1 unexpected character", rd_data, 0);
          else begin
            logic [10:0] e;
            e = expq.pop_front();
            chk(rd_data == e[9:0], "R1 order", rd_data, e[9:0]);
            in_pkt = !e[10];
          end
        end else begin
          chk(!in_pkt, "R4 idle inside packet", rd_data, 0);
        end
      end
    end
  end

  task automatic normal_phase(input int unsigned half, input string tag);
    do_reset();
    wr_half = half;
    sb_on = 1'b1;
    idles(6);
    repeat (10) @(negedge rd_clk);
    chk_valid = 1'b1;
    for (int p = 0; p < 40; p++) begin
      packet(1 + int'($urandom % 8));
      idles(2 + int'($urandom % 3));
    end
    idles(30);
    repeat (20) @(negedge rd_clk);
    // R1: everything written has come out
    chk(expq.size() == 0, {"R1 drained ", tag}, expq.size(), 0);
    // R3/R5: idle deletion keeps a fast writer from overflowing
    chk(!overflow, {"R3 R5 no overflow ", tag}, overflow, 0);
    // R6/R7: idle insertion keeps a slow writer from underflowing
    chk(!underflow, {"R6 R7 no underflow ", tag}, underflow, 0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    normal_phase(9800, "fast writer");
    normal_phase(10200, "slow writer");
    normal_phase(10000, "equal clocks");

    // R5: long packet from a much faster writer must overflow
    do_reset();
    wr_half = 5000;
    idles(8);
    packet(60);
    idles(10);
    repeat (10) @(negedge rd_clk);
    chk(overflow, "R5 overflow flagged", overflow, 1);
    repeat (10) @(negedge rd_clk);
    chk(overflow, "R5 overflow sticky", overflow, 1);

    // R7: long packet from a much slower writer must starve the reader
    do_reset();
    wr_half = 20000;
    sb_on = 1'b1;
    idles(6);
    packet(40);
    idles(10);
    repeat (10) @(negedge rd_clk);
    chk(underflow, "R7 underflow flagged", underflow, 1);
    chk(!overflow, "R7 no overflow", overflow, 0);
    chk(expq.size() == 0, "R1 drained after starvation", expq.size(), 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge rd_clk);
    if (!done) begin
      nvec++;
      nbad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule